// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Write Queue

This block is a direct-mapped data cache placed between a processor request port and a memory port that moves one 32-bit word per transaction. It holds 4096 lines. Each line has a valid flag, a 16-bit tag and a four-word data block. Read hits complete in the cycle they are presented. A read miss holds the processor while the whole four-word block is brought in, one word per memory transaction, in ascending word order. After the block is installed, the held read completes as a hit.

Writes follow a write-through policy. Each accepted write is posted into a four-slot FIFO of address/data pairs. The FIFO drains to memory one entry at a time, whenever the memory port is not busy with a refill. A write that hits also updates the cached word. A write that misses does not allocate a line. The processor is held on a write only while the FIFO is full. Before a refill starts, the FIFO must drain completely, so a refill can never return data older than a posted write.

The controller has three states. LOOKUP serves requests. DRAIN waits for the FIFO to empty. FILL runs the four word reads. The transitions are:
- LOOKUP to FILL, on a read miss when the FIFO is empty.
- LOOKUP to DRAIN, on a read miss while writes are still pending.
- DRAIN to FILL, when the FIFO becomes empty.
- FILL to LOOKUP, when the fourth word is acknowledged.

Top module: `wtc_cache`

## Requirements
- R1: After reset every line is invalid. With no request pending, `cpu_stall` and `mem_req` are low. The first read of any address misses: `cpu_hit` is low and the request stalls.
- R2: A read of a line that is valid and has a matching tag completes in the same cycle. `cpu_hit` is high, `cpu_stall` is low, no memory read is issued, and `cpu_rdata` is the word selected by address bits 3..2.
- R3: The address splits into tag bits 31..16, index bits 15..4 and word bits 3..2. Bits 1..0 do not affect which word is read. Two addresses with the same index and different tags share one line, so loading one evicts the other.
- R4: A read miss issues exactly four memory reads (`mem_we` low). Their addresses are block base +0, +4, +8 and +12, in that order. The held read then returns the word at its address.
- R5: A read miss issues no memory read while any posted write is still pending. A read that follows a write to the same block returns the written data.
- R6: Every accepted write reaches memory as one transaction with `mem_we` high, carrying the processor's address and data. Writes reach memory in the order they were accepted.
- R7: A write that hits completes without stalling and updates the cached word. A later read of that word hits and returns the new value.
- R8: A write that misses completes without fetching the block. No memory read is issued, and a later read of that address misses.
- R9: The FIFO holds four writes. While four writes are pending, a further write stalls until one has drained. The four writes before it do not stall.
- R10: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data; valid when a read completes |
| cpu_hit | output | 1 | Request hits a valid line with matching tag |
| cpu_stall | output | 1 | Request cannot complete this cycle; hold it |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Transaction complete, high for one cycle |

## Verification
The assertions make two assumptions about the memory side. They assume that `mem_ack` pulses for exactly one cycle. They also assume it arrives only while `mem_req` is high. They assume the processor keeps a stalled request, with its address and data, unchanged until `cpu_stall` drops. The bench's memory model counts a fixed latency from the first cycle of each request and answers with a single acknowledge pulse. Every processor access goes through one task, which holds the inputs steady until the stall clears and only then removes the request.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_FILL   = 2'd2
    } wtc_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wb_entry_t;
endpackage

// File: rtl/wtc_store.sv
`timescale 1ns/1ps
module wtc_store
    import wtc_pkg::*;
#(
    parameter int INDEX_W = 12,
    parameter int TAG_W   = 16,
    parameter int WSEL_W  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INDEX_W-1:0] lk_index,
    input  logic [WSEL_W-1:0]  lk_word,
    output logic               lk_valid,
    output logic [TAG_W-1:0]   lk_tag,
    output logic [WORD_W-1:0]  lk_data,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_index,
    input  logic [WSEL_W-1:0]  wr_word,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               inst_en,
    input  logic [INDEX_W-1:0] inst_index,
    input  logic [TAG_W-1:0]   inst_tag
);
    localparam int NUM_SETS = 1 << INDEX_W;
    localparam int WORDS    = 1 << WSEL_W;

    logic [NUM_SETS-1:0] valid_q;
    logic [TAG_W-1:0]    tag_mem [NUM_SETS];
    logic [WORD_W-1:0]   bank_rd [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (inst_en) begin
            valid_q[inst_index] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (inst_en) begin
            tag_mem[inst_index] <= inst_tag;
        end
    end

    // one storage bank per word of the block; word select muxes them
    for (genvar w = 0; w < WORDS; w++) begin : g_bank
        logic [WORD_W-1:0] mem_q [NUM_SETS];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_word == WSEL_W'(w))) begin
                mem_q[wr_index] <= wr_data;
            end
        end
        assign bank_rd[w] = mem_q[lk_index];
    end

    assign lk_valid = valid_q[lk_index];
    assign lk_tag   = tag_mem[lk_index];
    assign lk_data  = bank_rd[lk_word];

    AST_COLD_START: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0)); // R1
endmodule

// File: rtl/wtc_wbuf.sv
`timescale 1ns/1ps
module wtc_wbuf
    import wtc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  wb_entry_t push_entry,
    input  logic      pop,
    output wb_entry_t head,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    wb_entry_t          slots [DEPTH];
    logic [PTR_W-1:0]   rd_ptr, wr_ptr;
    logic [CNT_W-1:0]   count;

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = slots[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    AST_WB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !full); // R9
    AST_WB_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty); // R6
endmodule

// File: rtl/wtc_ctrl.sv
`timescale 1ns/1ps
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int WSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              lk_hit,
    input  logic              wb_empty,
    input  logic              wb_full,
    input  logic              mem_ack,
    output logic              accept,
    output logic              cpu_stall,
    output logic              cpu_hit,
    output logic              wb_push,
    output logic              miss_start,
    output logic              fill_active,
    output logic [WSEL_W-1:0] fill_word,
    output logic              fill_wr,
    output logic              fill_done
);
    localparam logic [WSEL_W-1:0] LAST_WORD = '1;

    wtc_state_t        state_q, state_d;
    logic [WSEL_W-1:0] fill_cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOOKUP;
        end else begin
            state_q <= state_d;
        end
    end

    // refill word counter
    always_ff @(posedge clk) begin
        if (rst || (state_q != ST_FILL)) begin
            fill_cnt_q <= '0;
        end else if (mem_ack) begin
            fill_cnt_q <= fill_cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP: begin
                if (cpu_req && !cpu_we && !lk_hit) begin
                    state_d = wb_empty ? ST_FILL : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (wb_empty) begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack && (fill_cnt_q == LAST_WORD)) begin
                    state_d = ST_LOOKUP;
                end
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

    // outputs
    always_comb begin
        accept      = 1'b0;
        cpu_hit     = 1'b0;
        miss_start  = 1'b0;
        fill_active = 1'b0;
        fill_wr     = 1'b0;
        fill_done   = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                cpu_hit    = cpu_req && lk_hit;
                accept     = cpu_req && (cpu_we ? !wb_full : lk_hit);
                miss_start = cpu_req && !cpu_we && !lk_hit;
            end
            ST_DRAIN: begin
            end
            ST_FILL: begin
                fill_active = 1'b1;
                fill_wr     = mem_ack;
                fill_done   = mem_ack && (fill_cnt_q == LAST_WORD);
            end
            default: begin
            end
        endcase
        cpu_stall = cpu_req && !accept;
        wb_push   = accept && cpu_we;
    end

    assign fill_word = fill_cnt_q;

    AST_FILL_ONLY_WHEN_DRAINED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL) |-> wb_empty); // R5
    AST_WRITE_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOKUP && cpu_req && cpu_we) |=> (state_q == ST_LOOKUP)); // R8
endmodule

// File: rtl/wtc_cache.sv
`timescale 1ns/1ps
module wtc_cache
    import wtc_pkg::*;
#(
    parameter int INDEX_W  = 12,
    parameter int WSEL_W   = 2,
    parameter int WB_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        cpu_hit,
    output logic        cpu_stall,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack
);
    localparam int BYTE_W = 2;
    localparam int TAG_W  = ADDR_W - INDEX_W - WSEL_W - BYTE_W;
    localparam int IDX_LO = WSEL_W + BYTE_W;
    localparam int TAG_LO = IDX_LO + INDEX_W;

    logic [TAG_W-1:0]   req_tag, lk_tag, miss_tag_q;
    logic [INDEX_W-1:0] req_index, miss_index_q, wr_index;
    logic [WSEL_W-1:0]  req_word, fill_word, wr_word;
    logic [WORD_W-1:0]  lk_data, wr_data;
    logic               lk_valid, lk_hit, wr_en;
    logic               accept, wb_push, miss_start;
    logic               fill_active, fill_wr, fill_done;
    logic               wb_empty, wb_full, wb_pop;
    wb_entry_t          wb_head, wb_new;

    assign req_tag   = cpu_addr[ADDR_W-1:TAG_LO];
    assign req_index = cpu_addr[TAG_LO-1:IDX_LO];
    assign req_word  = cpu_addr[IDX_LO-1:BYTE_W];
    assign lk_hit    = lk_valid && (lk_tag == req_tag);

    // capture the line being refilled
    always_ff @(posedge clk) begin
        if (rst) begin
            miss_tag_q   <= '0;
            miss_index_q <= '0;
        end else if (miss_start) begin
            miss_tag_q   <= req_tag;
            miss_index_q <= req_index;
        end
    end

    // word write port: refill data or processor write hit
    always_comb begin
        if (fill_wr) begin
            wr_en    = 1'b1;
            wr_index = miss_index_q;
            wr_word  = fill_word;
            wr_data  = mem_rdata;
        end else begin
            wr_en    = wb_push && lk_hit;
            wr_index = req_index;
            wr_word  = req_word;
            wr_data  = cpu_wdata;
        end
    end

    wtc_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .WSEL_W(WSEL_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .lk_index  (req_index),
        .lk_word   (req_word),
        .lk_valid  (lk_valid),
        .lk_tag    (lk_tag),
        .lk_data   (lk_data),
        .wr_en     (wr_en),
        .wr_index  (wr_index),
        .wr_word   (wr_word),
        .wr_data   (wr_data),
        .inst_en   (fill_done),
        .inst_index(miss_index_q),
        .inst_tag  (miss_tag_q)
    );

    assign wb_new.addr = cpu_addr;
    assign wb_new.data = cpu_wdata;
    assign wb_pop      = !fill_active && !wb_empty && mem_ack;

    wtc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
        .clk       (clk),
        .rst       (rst),
        .push      (wb_push),
        .push_entry(wb_new),
        .pop       (wb_pop),
        .head      (wb_head),
        .empty     (wb_empty),
        .full      (wb_full)
    );

    wtc_ctrl #(.WSEL_W(WSEL_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .lk_hit     (lk_hit),
        .wb_empty   (wb_empty),
        .wb_full    (wb_full),
        .mem_ack    (mem_ack),
        .accept     (accept),
        .cpu_stall  (cpu_stall),
        .cpu_hit    (cpu_hit),
        .wb_push    (wb_push),
        .miss_start (miss_start),
        .fill_active(fill_active),
        .fill_word  (fill_word),
        .fill_wr    (fill_wr),
        .fill_done  (fill_done)
    );

    // memory port: refill owns it in FILL, otherwise the queue head drains
    always_comb begin
        if (fill_active) begin
            mem_req   = 1'b1;
            mem_we    = 1'b0;
            mem_addr  = {miss_tag_q, miss_index_q, fill_word, {BYTE_W{1'b0}}};
            mem_wdata = '0;
        end else begin
            mem_req   = !wb_empty;
            mem_we    = 1'b1;
            mem_addr  = wb_head.addr;
            mem_wdata = wb_head.data;
        end
    end

    assign cpu_rdata = lk_data;

    AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we && cpu_hit) |-> !cpu_stall); // R2
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata))); // R10
endmodule

// File: tb/wtc_cache_test.sv
`timescale 1ns/1ps
module wtc_cache_test;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_hit, cpu_stall;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int n_checks = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wtc_cache uut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem_store [logic [29:0]];
    int          cyc = 0, wait_cnt = 0, proto_err = 0;
    logic [31:0] prev_addr, prev_wdata;
    logic        prev_we;
    logic [31:0] rd_log [64];
    int          rd_cyc [64];
    logic [31:0] wr_log_a [64], wr_log_d [64];
    int          wr_cyc [64];
    int          rd_n = 0, wr_n = 0;

    function automatic logic [31:0] dflt(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h0BAD_CAFE;
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] a);
        if (mem_store.exists(a[31:2])) return mem_store[a[31:2]];
        return dflt(a);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            mem_ack <= 1'b0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt > 0 && (mem_addr != prev_addr || mem_we != prev_we ||
                                 mem_wdata != prev_wdata)) proto_err++;
            prev_addr  = mem_addr;
            prev_we    = mem_we;
            prev_wdata = mem_wdata;
            wait_cnt++;
            if (wait_cnt == LAT) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem_store[mem_addr[31:2]] = mem_wdata;
                    if (wr_n < 64) begin
                        wr_log_a[wr_n] = mem_addr;
                        wr_log_d[wr_n] = mem_wdata;
                        wr_cyc[wr_n]   = cyc;
                    end
                    wr_n++;
                end else begin
                    mem_rdata <= word_at(mem_addr);
                    if (rd_n < 64) begin
                        rd_log[rd_n] = mem_addr;
                        rd_cyc[rd_n] = cyc;
                    end
                    rd_n++;
                end
            end
        end else begin
            if (wait_cnt > 0) proto_err++;
            wait_cnt = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int stalls, output bit hit0);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        hit0 = cpu_hit;
        stalls = 0;
        while (cpu_stall && stalls < 2000) begin
            @(negedge clk); #1;
            stalls++;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        for (int g = 0; g < 500 && quiet < 3; g++) begin
            @(negedge clk);
            if (mem_req) quiet = 0; else quiet++;
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_and_fill();
        logic [31:0] d; int s; bit h;
        check("R1", "stall idle after reset", {31'b0, cpu_stall}, 32'd0);
        check("R1", "mem_req idle after reset", {31'b0, mem_req}, 32'd0);
        access(1'b0, 32'h0000_1230, '0, d, s, h);
        check("R1", "first read hit flag", {31'b0, h}, 32'd0);
        check("R1", "first read stalled", {31'b0, (s > 0)}, 32'd1);
        check("R4", "miss read data", d, dflt(32'h0000_1230));
        check("R4", "reads per refill", rd_n, 32'd4);
        for (int i = 0; i < 4; i++)
            check("R4", "refill address order", rd_log[i], 32'h0000_1230 + 32'(4 * i));
    endtask

    task automatic t_hits();
        logic [31:0] d; int s; bit h;
        access(1'b0, 32'h0000_1237, '0, d, s, h);
        check("R3", "byte offset ignored", d, dflt(32'h0000_1234));
        check("R2", "hit flag", {31'b0, h}, 32'd1);
        check("R2", "hit no stall", s, 32'd0);
        access(1'b0, 32'h0000_123C, '0, d, s, h);
        check("R2", "word 3 select", d, dflt(32'h0000_123C));
        access(1'b0, 32'h0000_1230, '0, d, s, h);
        check("R2", "word 0 select", d, dflt(32'h0000_1230));
        check("R2", "no memory read on hits", rd_n, 32'd4);
    endtask

    task automatic t_conflict();
        logic [31:0] d; int s; bit h;
        access(1'b0, 32'h0005_1230, '0, d, s, h);
        check("R3", "same index new tag misses", {31'b0, h}, 32'd0);
        check("R3", "conflict data", d, dflt(32'h0005_1230));
        access(1'b0, 32'h0000_1230, '0, d, s, h);
        check("R3", "evicted line misses", {31'b0, h}, 32'd0);
        check("R3", "reloaded data", d, dflt(32'h0000_1230));
    endtask

    task automatic t_write_hit();
        logic [31:0] d; int s; bit h;
        access(1'b0, 32'h0000_2000, '0, d, s, h);
        access(1'b1, 32'h0000_2004, 32'hDEAD_0001, d, s, h);
        check("R7", "write hit flag", {31'b0, h}, 32'd1);
        check("R7", "write hit no stall", s, 32'd0);
        access(1'b0, 32'h0000_2004, '0, d, s, h);
        check("R7", "read after write hit", d, 32'hDEAD_0001);
        check("R7", "read after write is hit", {31'b0, h}, 32'd1);
        wait_idle();
        check("R6", "write reached memory", word_at(32'h0000_2004), 32'hDEAD_0001);
        check("R6", "write address", wr_log_a[wr_n-1], 32'h0000_2004);
    endtask

    task automatic t_write_miss();
        logic [31:0] d; int s; bit h; int rn;
        rn = rd_n;
        access(1'b1, 32'h0000_3008, 32'h0000_BEEF, d, s, h);
        check("R8", "write miss no stall", s, 32'd0);
        check("R8", "write miss hit flag", {31'b0, h}, 32'd0);
        wait_idle();
        check("R8", "no fetch on write miss", rd_n, rn);
        check("R6", "write miss in memory", word_at(32'h0000_3008), 32'h0000_BEEF);
        access(1'b0, 32'h0000_3008, '0, d, s, h);
        check("R8", "line not allocated", {31'b0, h}, 32'd0);
        check("R8", "read returns written", d, 32'h0000_BEEF);
    endtask

    task automatic t_stale();
        logic [31:0] d; int s; bit h; int rn, wn;
        rn = rd_n; wn = wr_n;
        access(1'b1, 32'h0000_4004, 32'h1234_5678, d, s, h);
        access(1'b0, 32'h0000_4004, '0, d, s, h);
        check("R5", "read sees posted write", d, 32'h1234_5678);
        check("R5", "refill after drain", {31'b0, (rd_cyc[rn] > wr_cyc[wn])}, 32'd1);
    endtask

    task automatic t_full();
        logic [31:0] d; int s; bit h; int wn;
        int st [5];
        wait_idle();
        wn = wr_n;
        for (int i = 0; i < 5; i++) begin
            access(1'b1, 32'h0000_5000 + 32'(4 * i), 32'h0000_00F0 + 32'(i), d, s, h);
            st[i] = s;
        end
        for (int i = 0; i < 4; i++) check("R9", "queue not full no stall", st[i], 32'd0);
        check("R9", "fifth write stalls", {31'b0, (st[4] > 0)}, 32'd1);
        wait_idle();
        check("R6", "write count", wr_n - wn, 32'd5);
        for (int i = 0; i < 5; i++) begin
            check("R6", "write order addr", wr_log_a[wn+i], 32'h0000_5000 + 32'(4 * i));
            check("R6", "write order data", wr_log_d[wn+i], 32'h0000_00F0 + 32'(i));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_and_fill();
        t_hits();
        t_conflict();
        t_write_hit();
        t_write_miss();
        t_stale();
        t_full();
        check("R10", "memory request held until ack", proto_err, 32'd0);
        finish_run();
    end

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule